// File: doc/BRIEF.md
# Programmable Timer / Event Counter with Divider Output

This block is an up-counter with a reload register. It can count the cycles in which an internal tick enable is high, or edges on an asynchronous event input, or the time an external input spends at its active level. When a counting step meets the all-ones value, the counter takes the reload value and does not roll through zero. That same step sets a sticky interrupt flag and toggles a divider flip-flop. With a reload value P, the divider produces a square wave whose period is 2·(2^WIDTH − P) counting steps.

Software controls the block through a small register port with a write strobe, an address, write data and a combinational read-back. The port reaches a control register, the reload register and the running count. The divider output reaches its pin only while its enable bit is set. In pulse-width mode the block stops itself at the end of the pulse, so the count holds the measured width.

Top module: `tmr_event_counter`

## Requirements
- R1: After reset the control register, the reload register, the count, the interrupt flag and div_out are all zero.
- R2: Register map by bus_addr. 0 is control: bits [1:0] mode, bit 2 polarity (0 = rising edge / active high, 1 = falling edge / active low), bit 3 run, bit 4 divider enable, and bit 5 reads the interrupt flag. 1 is reload, read and write. 2 is count, read only, and writes to it are ignored. 3 reads zero.
- R3: Mode 2'b10 adds one to the count on each clock edge where run is 1 and tick_en is 1.
- R4: Mode 2'b01 adds one for each active edge of evt_in after a two-flop synchroniser. The polarity bit selects which edge counts. tick_en has no effect in this mode.
- R5: Mode 2'b11 adds one on each tick while the synchronised evt_in is at its active level. At the first inactive edge the hardware clears run, so the count holds the pulse width in ticks.
- R6: Mode 2'b00 never changes the count, even with run set.
- R7: A reload write while run is 0 also copies the value into the count. While run is 1 it changes only the reload register.
- R8: A counting step taken at the all-ones count loads the reload value and sets the interrupt flag.
- R9: The interrupt flag is cleared only by a control write with bit 5 = 0. A control write with bit 5 = 1 leaves the flag as it is. A flag set and a clear in the same cycle leave the flag set.
- R10: The divider flip-flop toggles on every wrap, so its half-period is 2^WIDTH − reload counting steps.
- R11: div_out follows the divider flip-flop while bit 4 is 1 and is held at 0 while bit 4 is 0.
- R12: Clearing run freezes the count at its present value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one register write per cycle |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for bus_addr |
| tick_en | input | 1 | Internal clock enable, one pulse per tick |
| evt_in | input | 1 | Asynchronous external event / gate input |
| irq | output | 1 | Sticky interrupt request flag |
| div_out | output | 1 | Gated divider output |

## Verification
The assertions assume that the register port makes at most one write per cycle. They also assume that software clears the flag or rewrites run only through the control register, so that a hardware stop and a software write never need to be told apart. The bench drives every input on the falling clock edge. It holds tick_en low across register accesses unless a measurement needs it running. It keeps each level of evt_in for at least three cycles, so that no edge is lost in the synchroniser. The sweeps keep each count below the wrap point except in the divider tests, where wraps are intended.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TICK  = 2'b10,
    MODE_WIDTH = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      out_en;
    logic      run;
    logic      edge_neg;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;

  localparam int CTRL_BITS = $bits(tmr_ctrl_t);

endpackage

// File: rtl/tmr_in_sync.sv
module tmr_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             run,
  input  logic             load_wr,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] reload,
  output logic             wrap
);
  function automatic logic at_top(input logic [WIDTH-1:0] v);
    return &v;
  endfunction

  function automatic logic [WIDTH-1:0] advance(input logic [WIDTH-1:0] v,
                                               input logic [WIDTH-1:0] r);
    return at_top(v) ? r : v + 1'b1;
  endfunction

  assign wrap = step & at_top(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
    end else begin
      if (load_wr) reload <= load_data;
      if (step)                 count <= advance(count, reload);
      else if (load_wr && !run) count <= load_data;
    end
  end
endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_wr,
  input  logic [CTRL_BITS:0]   ctrl_wdata,
  input  logic                 width_done,
  input  logic                 wrap,
  output tmr_ctrl_t            ctrl,
  output logic                 irq_flag,
  output logic                 div_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      irq_flag <= 1'b0;
      div_q    <= 1'b0;
    end else begin
      if (ctrl_wr)         ctrl     <= tmr_ctrl_t'(ctrl_wdata[CTRL_BITS-1:0]);
      else if (width_done) ctrl.run <= 1'b0;
      if (wrap)                                irq_flag <= 1'b1;
      else if (ctrl_wr && !ctrl_wdata[CTRL_BITS]) irq_flag <= 1'b0;
      if (wrap) div_q <= ~div_q;
    end
  end
endmodule

// File: rtl/tmr_event_counter.sv
module tmr_event_counter
  import tmr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             tick_en,
  input  logic             evt_in,
  output logic             irq,
  output logic             div_out
);
  localparam int PAD = WIDTH - CTRL_BITS - 1;

  tmr_ctrl_t        ctrl;
  logic             irq_flag, div_q;
  logic             ev_level, ev_rise, ev_fall;
  logic             act_edge, act_level, inact_edge;
  logic             step_req, step, width_done, wrap;
  logic             ctrl_wr, load_wr;
  logic [WIDTH-1:0] count, reload;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
  assign load_wr = bus_wr && (bus_addr == ADDR_RELOAD);

  tmr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(evt_in),
    .level(ev_level), .rise(ev_rise), .fall(ev_fall)
  );

  assign act_edge   = ctrl.edge_neg ? ev_fall : ev_rise;
  assign inact_edge = ctrl.edge_neg ? ev_rise : ev_fall;
  assign act_level  = ev_level ^ ctrl.edge_neg;

  always_comb begin
    unique case (ctrl.mode)
      MODE_EVENT: step_req = act_edge;
      MODE_TICK:  step_req = tick_en;
      MODE_WIDTH: step_req = tick_en & act_level;
      default:    step_req = 1'b0;
    endcase
  end

  assign step       = ctrl.run & step_req;
  assign width_done = ctrl.run & (ctrl.mode == MODE_WIDTH) & inact_edge;

  tmr_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .run(ctrl.run),
    .load_wr(load_wr), .load_data(bus_wdata),
    .count(count), .reload(reload), .wrap(wrap)
  );

  tmr_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(bus_wdata[CTRL_BITS:0]), .width_done(width_done),
    .wrap(wrap), .ctrl(ctrl), .irq_flag(irq_flag), .div_q(div_q)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL:   bus_rdata = {{PAD{1'b0}}, irq_flag, ctrl};
      ADDR_RELOAD: bus_rdata = reload;
      ADDR_COUNT:  bus_rdata = count;
      default:     bus_rdata = '0;
    endcase
  end

  assign irq     = irq_flag;
  assign div_out = div_q & ctrl.out_en;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             wrap,
  input logic             load_wr,
  input logic             ctrl_wr,
  input logic             width_done,
  input logic             run,
  input logic             out_en,
  input logic             div_q,
  input logic             div_out,
  input logic             irq,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] reload
);
  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == $past(reload)); // R8
  AST_WRAP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> irq); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_wr) |=> irq); // R9
  AST_DIV_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> div_q != $past(div_q)); // R10
  AST_DIV_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(div_q)); // R10
  AST_DIV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !div_out); // R11
  AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wrap) |=> count == $past(count) + 1'b1); // R3
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_wr) |=> $stable(count)); // R12
  AST_STOPPED_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !step); // R12
  AST_WIDTH_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (width_done && !ctrl_wr) |=> !run); // R5
endmodule

bind tmr_event_counter tmr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .wrap(wrap), .load_wr(load_wr),
  .ctrl_wr(ctrl_wr), .width_done(width_done), .run(ctrl.run),
  .out_en(ctrl.out_en), .div_q(div_q), .div_out(div_out), .irq(irq),
  .count(count), .reload(reload)
);

// File: tb/sim_tmr_event_counter.sv
module sim_tmr_event_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tick_en = 1'b0;
  logic       evt_in = 1'b0;
  logic       irq, div_out;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  tmr_event_counter u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .evt_in(evt_in), .irq(irq), .div_out(div_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int ones, span, gap;
    logic prev;

    idle(3);
    #1;
    check("R1 div_out", div_out, 0);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 reload", v, 0);
    rd(2'd2, v); check("R1 count", v, 0);

    // R2 / R7: map, stopped reload write copies into the count
    wr(2'd1, 8'h5A);
    rd(2'd1, v); check("R2 reload readback", v, 8'h5A);
    rd(2'd2, v); check("R7 stopped copy", v, 8'h5A);
    wr(2'd2, 8'h11);
    rd(2'd2, v); check("R2 count write ignored", v, 8'h5A);
    rd(2'd3, v); check("R2 addr3 zero", v, 0);
    wr(2'd0, 8'h14);
    rd(2'd0, v); check("R2 ctrl readback", v, 8'h14);

    // R6: mode 00 with run set
    wr(2'd0, 8'h08);
    tick_en = 1'b1; idle(10); tick_en = 1'b0;
    rd(2'd2, v); check("R6 idle mode", v, 8'h5A);

    // R3 / R12: tick sweep with varying enable patterns
    for (int k = 0; k < 24; k++) begin
      wr(2'd0, 8'h02);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h0A);
      ones = 0;
      for (int i = 0; i < k; i++) begin
        @(negedge clk);
        tick_en = ((i * (k + 1)) % 3) != 0;
        if (tick_en) ones++;
      end
      @(negedge clk); tick_en = 1'b0;
      rd(2'd2, v); check("R3 tick count", v, ones);
    end
    wr(2'd0, 8'h02);
    tick_en = 1'b1; idle(6); tick_en = 1'b0;
    rd(2'd2, v); check("R12 frozen when stopped", v, ones);

    // R7: reload write while running leaves the count
    wr(2'd0, 8'h0A);
    wr(2'd1, 8'h33);
    rd(2'd2, v); check("R7 running no copy", v, ones);
    rd(2'd1, v); check("R7 running reload", v, 8'h33);

    // R8 / R10: divider half-period sweep over reload values
    foreach (span_list[j]) begin
      wr(2'd0, 8'h00);
      wr(2'd1, span_list[j]);
      span = 256 - span_list[j];
      tick_en = 1'b1;
      wr(2'd0, 8'h1A);
      bus_addr = 2'd2;
      check("R9 cleared before run", irq, 0);
      for (int h = 0; h < 2; h++) begin
        prev = div_out; gap = 0;
        do begin
          @(negedge clk); gap++;
        end while (div_out == prev && gap < 400);
        check("R10 half period", gap, span);
        check("R8 reload on wrap", bus_rdata, span_list[j]);
        check("R8 irq set", irq, 1);
      end
      tick_en = 1'b0;
    end

    // R11: gated divider stays low while wraps continue
    wr(2'd0, 8'h02);
    wr(2'd1, 8'hFD);
    tick_en = 1'b1;
    wr(2'd0, 8'h0A);
    ones = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (div_out) ones++;
    end
    check("R11 gated low", ones, 0);
    tick_en = 1'b0;
    wr(2'd0, 8'h1A);
    prev = div_out;
    tick_en = 1'b1; idle(3); tick_en = 1'b0;
    check("R11 enabled follows", div_out, !prev);

    // R9: flag clears only with bit 5 = 0
    wr(2'd0, 8'h22);
    check("R9 write-1 keeps", irq, 1);
    rd(2'd0, v); check("R9 flag readback", v[5], 1);
    wr(2'd0, 8'h02);
    check("R9 write-0 clears", irq, 0);

    // R4: edge counting, both polarities, ticks ignored
    for (int pol = 0; pol < 2; pol++) begin
      for (int n = 1; n <= 6; n++) begin
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h00);
        evt_in = 1'b0; idle(4);
        wr(2'd0, pol ? 8'h0D : 8'h09);
        tick_en = 1'b1;
        for (int p = 0; p < n; p++) begin
          evt_in = 1'b1; idle(3);
          evt_in = 1'b0; idle(3);
        end
        idle(4); tick_en = 1'b0;
        rd(2'd2, v); check(pol ? "R4 falling edges" : "R4 rising edges", v, n);
      end
    end

    // R5: pulse width capture, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int w = 1; w <= 12; w++) begin
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h00);
        evt_in = pol[0]; idle(4);
        wr(2'd0, pol ? 8'h0F : 8'h0B);
        tick_en = 1'b1; idle(3);
        evt_in = !pol[0]; idle(w);
        evt_in = pol[0]; idle(5);
        evt_in = !pol[0]; idle(4);
        evt_in = pol[0]; idle(4);
        tick_en = 1'b0;
        rd(2'd2, v); check("R5 width", v, w);
        rd(2'd0, v); check("R5 run cleared", v[3], 0);
      end
    end
    evt_in = 1'b0;
    finish_run();
  end

  logic [7:0] span_list [5] = '{8'h00, 8'h80, 8'hF0, 8'hFE, 8'hFF};
endmodule